// File: doc/BRIEF.md
# GPIO and Control Register File

This block is a small 16-bit register file reached over a single-cycle memory-mapped bus. It keeps a set of plain storage registers (mode, configuration data, clock control, and three interrupt-related words), a power word with a forcing side effect, a constant status word, and a GPIO section. The GPIO section has a direction register, a shared level register, and 16 output lines.

Each output line carries the AND of its level bit and its direction bit. The output vector is refreshed only when software writes the direction or the level register, and only the bits that change are touched. Sixteen external input lines each carry a per-line strobe and a level. A strobe loads that level into the matching bit of the level register without refreshing the outputs. Bus writes to the level register are masked by direction before they are stored.

Read data is registered and appears one cycle after the request.

Top module: `pio_regfile`

## Requirements
- R1: The register is selected by address bits [5:2] when bits [1:0] are zero. Byte offsets: 0x00 mode, 0x04 configuration, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 GPIO write, 0x28 GPIO read. Only the low 16 bits of the bus write data are stored.
- R2: A read request (valid high, write low) returns its data on `bus_rdata` at the next clock edge. `bus_rdata` holds its value in every cycle without a read request, including write cycles.
- R3: After reset, every register reads zero except status, and `gpio_out` and `bus_rdata` are zero.
- R4: Status always reads 0x0002. Reads of unmapped or misaligned offsets return zero. Writes to status, to unmapped offsets or to misaligned offsets change nothing.
- R5: A power write stores the value. When bit 7 of the value is 1, bits 15 and 6 are also set (value OR 0x8040).
- R6: A write to offset 0x24 or 0x28 stores the data ANDed with the current direction into the level register. Both offsets read back the level register.
- R7: After a write to direction or level, `gpio_out` equals level AND direction. Bits whose value is unchanged are not updated.
- R8: When `ext_we[i]` is 1, level bit i takes `ext_lvl[i]` at the clock edge. This does not change `gpio_out` until the next write to direction or level.
- R9: When a bus write to the level register and an external strobe hit the same bit in the same cycle, the bus write wins.
- R10: Mode, configuration, clock control and the three interrupt words are plain storage. Each reads back exactly what was last written to it, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (6) | Byte address of the register |
| bus_wdata | input | BUS_W (32) | Write data; only the low DW bits are kept |
| bus_rdata | output | DW (16) | Registered read data |
| ext_we | input | NLINES (16) | Per-line strobe that loads an external level |
| ext_lvl | input | NLINES (16) | External level for each line |
| gpio_out | output | NLINES (16) | Effective GPIO outputs (level AND direction) |

## Verification
The bench builds the block with its defaults. The bus data is 32 bits wide against 16-bit registers, so the upper half of each write is visible and its truncation can be checked. The full 16 lines match the register width, so direction masking can be checked across both bytes. The power forcing option is enabled. A 6-bit address also reaches the misaligned offsets and the unmapped offsets above 0x28. Keeping the line count equal to the data width lets each read of a GPIO register expose every line, including lines whose direction bit is clear.

// File: rtl/pio_regfile_pkg.sv
package pio_regfile_pkg;

   localparam int NREG = 16;
   localparam int IDX_W = 4;

   typedef enum logic [IDX_W-1:0] {
      RI_MODE    = 4'd0,
      RI_CFG     = 4'd1,
      RI_STAT    = 4'd2,
      RI_PWR     = 4'd3,
      RI_CLK     = 4'd4,
      RI_IRQ_REQ = 4'd5,
      RI_IRQ_MSK = 4'd6,
      RI_IRQ_STS = 4'd7,
      RI_DIR     = 4'd8,
      RI_LVL_W   = 4'd9,
      RI_LVL_R   = 4'd10
   } reg_idx_e;

   // true for registers that only store what is written
   function automatic bit is_plain(input int k);
      return (k == int'(RI_MODE))    || (k == int'(RI_CFG))     ||
             (k == int'(RI_CLK))     || (k == int'(RI_IRQ_REQ)) ||
             (k == int'(RI_IRQ_MSK)) || (k == int'(RI_IRQ_STS));
   endfunction

endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
   import pio_regfile_pkg::*;
(
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [5:0]      req_addr,
   output logic [NREG-1:0] wr_en,
   output logic            rd_en,
   output logic            rd_ok,
   output logic [IDX_W-1:0] rd_idx
);
   logic             aligned;
   logic [IDX_W-1:0] idx;
   logic             mapped;

   assign idx     = req_addr[5:2];
   assign aligned = (req_addr[1:0] == 2'b00);
   assign mapped  = aligned && (idx <= RI_LVL_R);

   assign rd_en  = req_valid && !req_write;
   assign rd_ok  = mapped;
   assign rd_idx = idx;

   for (genvar k = 0; k < NREG; k++) begin : g_wsel
      if (k <= int'(RI_LVL_R) && k != int'(RI_STAT)) begin : g_map
         assign wr_en[k] = req_valid && req_write && aligned && (idx == IDX_W'(k));
      end else begin : g_none
         assign wr_en[k] = 1'b0;
      end
   end

endmodule

// File: rtl/pio_ctl_bank.sv
module pio_ctl_bank
   import pio_regfile_pkg::*;
#(
   parameter int          DW           = 16,
   parameter logic [DW-1:0] STATUS_RST = 16'h0002,
   parameter int          PWR_TRIG     = 7,
   parameter logic [DW-1:0] PWR_FORCE  = 16'h8040,
   parameter bit          PWR_FORCE_EN = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREG-1:0]          wr_en,
   input  logic [DW-1:0]            wdata,
   output logic [NREG-1:0][DW-1:0]  q
);
   logic [DW-1:0] pwr_nx;

   if (PWR_FORCE_EN) begin : g_force
      assign pwr_nx = wdata[PWR_TRIG] ? (wdata | PWR_FORCE) : wdata;
   end else begin : g_noforce
      assign pwr_nx = wdata;
   end

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      if (k == int'(RI_PWR)) begin : g_pwr
         logic [DW-1:0] r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        r <= '0;
            else if (wr_en[k]) r <= pwr_nx;
         assign q[k] = r;
      end else if (is_plain(k)) begin : g_plain
         logic [DW-1:0] r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        r <= '0;
            else if (wr_en[k]) r <= wdata;
         assign q[k] = r;
      end else if (k == int'(RI_STAT)) begin : g_stat
         logic unused_we;
         assign unused_we = wr_en[k];
         assign q[k] = STATUS_RST;
      end else begin : g_zero
         logic unused_we;
         assign unused_we = wr_en[k];
         assign q[k] = '0;
      end
   end

   if (PWR_FORCE_EN) begin : g_pwr_chk
      AST_PWR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en[RI_PWR] && wdata[PWR_TRIG] |=> ((q[RI_PWR] & PWR_FORCE) == PWR_FORCE)); // R5
   end
   AST_PWR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[RI_PWR] && !wdata[PWR_TRIG] |=> (q[RI_PWR] == $past(wdata))); // R5

endmodule

// File: rtl/pio_gpio_core.sv
module pio_gpio_core #(
   parameter int NLINES = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dir,
   input  logic              wr_lvl,
   input  logic [NLINES-1:0] wdata,
   input  logic [NLINES-1:0] ext_we,
   input  logic [NLINES-1:0] ext_lvl,
   output logic [NLINES-1:0] dir_q,
   output logic [NLINES-1:0] lvl_q,
   output logic [NLINES-1:0] gpio_out
);
   logic [NLINES-1:0] dir_nx;
   logic [NLINES-1:0] lvl_bus;
   logic [NLINES-1:0] eff_nx;
   logic              refresh;

   assign dir_nx  = wr_dir ? wdata : dir_q;
   assign lvl_bus = wdata & dir_q;
   assign eff_nx  = (wr_lvl ? lvl_bus : lvl_q) & dir_nx;
   assign refresh = wr_dir || wr_lvl;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dir_q <= '0;
      else        dir_q <= dir_nx;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)         lvl_q[i] <= 1'b0;
         else if (wr_lvl)    lvl_q[i] <= lvl_bus[i];
         else if (ext_we[i]) lvl_q[i] <= ext_lvl[i];

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                                 gpio_out[i] <= 1'b0;
         else if (refresh && (eff_nx[i] != gpio_out[i])) gpio_out[i] <= eff_nx[i];
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh |=> $stable(gpio_out)); // R8
   AST_OUT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      refresh && (ext_we == '0) |=> (gpio_out == (lvl_q & dir_q))); // R7
   AST_LVL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lvl |=> ((lvl_q & ~dir_q) == '0)); // R6
   AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lvl |=> (lvl_q == ($past(wdata) & dir_q))); // R9

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
   import pio_regfile_pkg::*;
#(
   parameter int            AW           = 6,
   parameter int            BUS_W        = 32,
   parameter int            DW           = 16,
   parameter int            NLINES       = 16,
   parameter logic [DW-1:0] STATUS_RST   = 16'h0002,
   parameter int            PWR_TRIG     = 7,
   parameter logic [DW-1:0] PWR_FORCE    = 16'h8040,
   parameter bit            PWR_FORCE_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NLINES-1:0] ext_we,
   input  logic [NLINES-1:0] ext_lvl,
   output logic [NLINES-1:0] gpio_out
);
   if (AW < 6)            begin : g_bad_aw  $error("AW must cover the 6-bit register window"); end
   if (BUS_W < DW)        begin : g_bad_bw  $error("BUS_W must be at least DW"); end
   if (NLINES > DW)       begin : g_bad_nl  $error("NLINES must fit in DW"); end
   if (PWR_TRIG >= DW)    begin : g_bad_pt  $error("PWR_TRIG outside the register"); end

   logic [DW-1:0]           wdata;
   logic [NREG-1:0]         wr_en;
   logic                    rd_en;
   logic                    rd_ok;
   logic [IDX_W-1:0]        rd_idx;
   logic [NREG-1:0][DW-1:0] bank_q;
   logic [NLINES-1:0]       dir_q;
   logic [NLINES-1:0]       lvl_q;
   logic [DW-1:0]           rd_mux;

   assign wdata = bus_wdata[DW-1:0];

   if (BUS_W > DW) begin : g_wtrunc
      logic unused_hi;
      assign unused_hi = ^bus_wdata[BUS_W-1:DW];
   end
   if (AW > 6) begin : g_atrunc
      logic unused_ahi;
      assign unused_ahi = ^bus_addr[AW-1:6];
   end

   pio_addr_dec u_dec (
      .req_valid (bus_valid),
      .req_write (bus_write),
      .req_addr  (bus_addr[5:0]),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .rd_ok     (rd_ok),
      .rd_idx    (rd_idx)
   );

   pio_ctl_bank #(
      .DW           (DW),
      .STATUS_RST   (STATUS_RST),
      .PWR_TRIG     (PWR_TRIG),
      .PWR_FORCE    (PWR_FORCE),
      .PWR_FORCE_EN (PWR_FORCE_EN)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (wdata),
      .q     (bank_q)
   );

   pio_gpio_core #(.NLINES(NLINES)) u_gpio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_dir   (wr_en[RI_DIR]),
      .wr_lvl   (wr_en[RI_LVL_W] || wr_en[RI_LVL_R]),
      .wdata    (wdata[NLINES-1:0]),
      .ext_we   (ext_we),
      .ext_lvl  (ext_lvl),
      .dir_q    (dir_q),
      .lvl_q    (lvl_q),
      .gpio_out (gpio_out)
   );

   always_comb begin
      rd_mux = '0;
      if (rd_ok) begin
         case (rd_idx)
            RI_DIR:             rd_mux[NLINES-1:0] = dir_q;
            RI_LVL_W, RI_LVL_R: rd_mux[NLINES-1:0] = lvl_q;
            default:            rd_mux = bank_q[rd_idx];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(bus_rdata)); // R2
   AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_ok && (rd_idx == RI_STAT) |=> (bus_rdata == STATUS_RST)); // R4
   AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_ok |=> (bus_rdata == '0)); // R4

endmodule

// File: tb/sim_pio_regfile.sv
`timescale 1ns/1ps
module sim_pio_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] ext_we = '0;
   logic [15:0] ext_lvl = '0;
   logic [15:0] gpio_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pio_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_we(ext_we), .ext_lvl(ext_lvl), .gpio_out(gpio_out)
   );

   typedef struct packed {
      logic        wr;
      logic [5:0]  addr;
      logic [31:0] wd;
      logic [15:0] rd;
      logic [15:0] out;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 37;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 6'h00, 32'hABCD1234, 16'h0000, 16'h0000, 4'd1},  // R1 upper half dropped
      '{1'b0, 6'h00, 32'h0,        16'h1234, 16'h0000, 4'd1},
      '{1'b1, 6'h04, 32'h0000BEEF, 16'h0000, 16'h0000, 4'd10}, // R10
      '{1'b0, 6'h04, 32'h0,        16'hBEEF, 16'h0000, 4'd10},
      '{1'b1, 6'h10, 32'h00005A5A, 16'h0000, 16'h0000, 4'd10},
      '{1'b0, 6'h10, 32'h0,        16'h5A5A, 16'h0000, 4'd10},
      '{1'b1, 6'h14, 32'h00001111, 16'h0000, 16'h0000, 4'd10},
      '{1'b0, 6'h14, 32'h0,        16'h1111, 16'h0000, 4'd10},
      '{1'b1, 6'h18, 32'h00002222, 16'h0000, 16'h0000, 4'd10},
      '{1'b0, 6'h18, 32'h0,        16'h2222, 16'h0000, 4'd10},
      '{1'b1, 6'h1C, 32'h00003333, 16'h0000, 16'h0000, 4'd10},
      '{1'b0, 6'h1C, 32'h0,        16'h3333, 16'h0000, 4'd10},
      '{1'b1, 6'h0C, 32'h00000080, 16'h0000, 16'h0000, 4'd5},  // R5 forcing
      '{1'b0, 6'h0C, 32'h0,        16'h80C0, 16'h0000, 4'd5},
      '{1'b1, 6'h0C, 32'h00000001, 16'h0000, 16'h0000, 4'd5},
      '{1'b0, 6'h0C, 32'h0,        16'h0001, 16'h0000, 4'd5},
      '{1'b1, 6'h0C, 32'h0000FF7F, 16'h0000, 16'h0000, 4'd5},
      '{1'b0, 6'h0C, 32'h0,        16'hFF7F, 16'h0000, 4'd5},
      '{1'b1, 6'h08, 32'h0000FFFF, 16'h0000, 16'h0000, 4'd4},  // R4 status read-only
      '{1'b0, 6'h08, 32'h0,        16'h0002, 16'h0000, 4'd4},
      '{1'b1, 6'h2C, 32'h0000FFFF, 16'h0000, 16'h0000, 4'd4},
      '{1'b0, 6'h2C, 32'h0,        16'h0000, 16'h0000, 4'd4},
      '{1'b0, 6'h3C, 32'h0,        16'h0000, 16'h0000, 4'd4},
      '{1'b1, 6'h24, 32'h0000FFFF, 16'h0000, 16'h0000, 4'd6},  // R6 all masked
      '{1'b0, 6'h24, 32'h0,        16'h0000, 16'h0000, 4'd6},
      '{1'b1, 6'h20, 32'h000000FF, 16'h0000, 16'h0000, 4'd7},  // R7
      '{1'b0, 6'h20, 32'h0,        16'h00FF, 16'h0000, 4'd7},
      '{1'b1, 6'h24, 32'h1234A5A5, 16'h0000, 16'h00A5, 4'd6},
      '{1'b0, 6'h28, 32'h0,        16'h00A5, 16'h00A5, 4'd6},
      '{1'b0, 6'h24, 32'h0,        16'h00A5, 16'h00A5, 4'd6},
      '{1'b1, 6'h20, 32'h00000F0F, 16'h0000, 16'h0005, 4'd7},
      '{1'b0, 6'h24, 32'h0,        16'h00A5, 16'h0005, 4'd7},
      '{1'b1, 6'h28, 32'h0000FFFF, 16'h0000, 16'h0F0F, 4'd6},
      '{1'b0, 6'h28, 32'h0,        16'h0F0F, 16'h0F0F, 4'd6},
      '{1'b1, 6'h02, 32'h0000FFFF, 16'h0000, 16'h0F0F, 4'd4},  // R4 misaligned
      '{1'b0, 6'h00, 32'h0,        16'h1234, 16'h0F0F, 4'd4},
      '{1'b0, 6'h01, 32'h0,        16'h0000, 16'h0F0F, 4'd4}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus(input logic wr, input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic ext(input logic [15:0] we, input logic [15:0] lv);
      @(negedge clk);
      ext_we = we; ext_lvl = lv;
      @(posedge clk);
      @(negedge clk);
      ext_we = '0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3 reset state
      chk("R3 out", gpio_out, 16'h0000);
      chk("R3 rdata", bus_rdata, 16'h0000);
      rst_n = 1'b1;
      bus(1'b0, 6'h08, '0); chk("R3 status", bus_rdata, 16'h0002);
      bus(1'b0, 6'h20, '0); chk("R3 dir", bus_rdata, 16'h0000);
      bus(1'b0, 6'h0C, '0); chk("R3 power", bus_rdata, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         bus(VEC[i].wr, VEC[i].addr, VEC[i].wd);
         if (!VEC[i].wr)
            chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), bus_rdata, VEC[i].rd);
         chk($sformatf("R%0d vec%0d out", VEC[i].req, i), gpio_out, VEC[i].out);
      end

      // R2 read data holds across writes and idle cycles
      bus(1'b0, 6'h04, '0);
      chk("R2 read", bus_rdata, 16'hBEEF);
      bus(1'b1, 6'h04, 32'h0001);
      chk("R2 hold on write", bus_rdata, 16'hBEEF);
      @(negedge clk);
      chk("R2 hold idle", bus_rdata, 16'hBEEF);
      bus(1'b0, 6'h04, '0);
      chk("R10 cfg rewrite", bus_rdata, 16'h0001);

      // R8 external strobes load level, outputs stay put
      ext(16'h8000, 16'h8000);
      chk("R8 out after set", gpio_out, 16'h0F0F);
      bus(1'b0, 6'h24, '0);
      chk("R8 level set", bus_rdata, 16'h8F0F);
      ext(16'h0001, 16'h0000);
      chk("R8 out after clear", gpio_out, 16'h0F0F);
      bus(1'b0, 6'h28, '0);
      chk("R8 level clear", bus_rdata, 16'h8F0E);
      bus(1'b1, 6'h20, 32'hFFFF);
      chk("R7 refresh on dir", gpio_out, 16'h8F0E);

      // R9 bus write beats a same-cycle strobe
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'h24; bus_wdata = 32'h0008;
      ext_we = 16'h8008; ext_lvl = 16'h8000;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; ext_we = '0;
      chk("R9 out", gpio_out, 16'h0008);
      bus(1'b0, 6'h24, '0);
      chk("R9 level", bus_rdata, 16'h0008);

      // R3 reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R3 out again", gpio_out, 16'h0000);
      chk("R3 rdata again", bus_rdata, 16'h0000);
      rst_n = 1'b1;
      bus(1'b0, 6'h24, '0); chk("R3 level", bus_rdata, 16'h0000);
      bus(1'b0, 6'h00, '0); chk("R3 mode", bus_rdata, 16'h0000);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule